// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Port-Driven Break

This block serialises one data byte at a time onto a single transmit line. Each character is a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Every bit is held for 16 pulses of an oversample tick, which is the same rate a matching receiver uses. Software writes a byte into a one-entry holding buffer. The shifter takes the byte as soon as it is idle. Two flags report the buffer state and whether the line has finished sending.

A transmit enable decides what drives the line. With the enable high, the shifter drives the line, and the line sits at mark while nothing is being sent. With the enable low, the line follows a port level register that software writes. That register comes out of reset at 1, so the line holds mark before transmission is enabled. Clearing the enable puts the transmitter back into idle at once, even partway through a character. To send a break, software first writes 0 to the port level and then clears the enable. The line stays low until software changes one of the two.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1, tx_end is 1, and the port level register holds 1.
- R2: While tx_en is 0, txd equals the port level register. A cycle with port_wr high loads port_din into that register, and the new value appears on txd after that edge.
- R3: While tx_en is 1, the shifter drives txd and the port level has no effect. A character is sent as start 0, then data bit 0 through bit 7, then, when par_en is 1, a parity bit, then stop 1. The parity bit is the XOR of the data bits when par_odd is 0, and its inverse when par_odd is 1. When no character is being sent, txd is 1.
- R4: Each bit of a character lasts 16 tick16 pulses.
- R5: A wr_stb while tx_en is 1 stores wr_data and clears buf_empty on the next edge. buf_empty sets again when the byte moves into the shifter.
- R6: tx_end clears when a character starts. It sets at the end of the stop bit if buf_empty is 1 at that time.
- R7: Clearing tx_en aborts any character in progress. On the next edge the transmitter is idle with buf_empty 1 and tx_end 1. Setting tx_en again does not resume the aborted character; the line stays at mark.
- R8: A wr_stb while tx_en is 0 is ignored. After tx_en is set again, nothing is sent and buf_empty stays 1.
- R9: Writing 0 to the port level and then clearing tx_en holds txd at 0 for as long as tx_en stays 0. Writing the port level back to 1 returns the line to mark.
- R10: A byte written while a character is in progress is sent directly after that character's stop bit, and both characters arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample tick, 16 per bit time |
| wr_data | input | 8 | Byte to transmit |
| wr_stb | input | 1 | Write strobe for wr_data |
| tx_en | input | 1 | Transmit enable; low resets the transmitter |
| port_wr | input | 1 | Write strobe for the port level |
| port_din | input | 1 | New port level |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| txd | output | 1 | Serial transmit line |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| tx_end | output | 1 | Line idle after the last stop bit |

## Verification
The bench aborts a character during its start bit with the port level at 1. A design that only stopped at a character boundary would keep the line low there, and a design that froze instead of resetting would finish the byte once re-enabled. It holds a break for hundreds of cycles, which catches a port level that is ignored or that the shifter overrides. It also writes a byte while the enable is low, which catches a design that sends that byte later. Start-bit length and parity in both senses catch an off-by-one in the tick counter and an inverted parity rule.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_stb,
  input  logic          tx_en,
  input  logic          port_wr,
  input  logic          port_din,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          txd,
  output logic          buf_empty,
  output logic          tx_end
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);

  logic          port_q, busy, par_on, par_q;
  logic [DW-1:0] dbuf, sh;
  logic [BW-1:0] idx;
  logic [CW-1:0] tcnt;
  logic          cur_bit;
  logic [BW-1:0] last_idx;

  assign last_idx = par_on ? BW'(DW + 2) : BW'(DW + 1);

  always_comb begin
    if (idx == '0)                                  cur_bit = 1'b0;
    else if (idx <= BW'(DW))                        cur_bit = sh[0];
    else if (idx == BW'(DW + 1) && par_on)          cur_bit = par_q;
    else                                            cur_bit = 1'b1;
  end

  assign txd = tx_en ? (busy ? cur_bit : 1'b1) : port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q    <= 1'b1;
      busy      <= 1'b0;
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
      idx       <= '0;
      tcnt      <= '0;
      dbuf      <= '0;
      sh        <= '0;
      par_on    <= 1'b0;
      par_q     <= 1'b0;
    end else begin
      if (port_wr) port_q <= port_din;
      if (!tx_en) begin
        busy      <= 1'b0;
        buf_empty <= 1'b1;
        tx_end    <= 1'b1;
        idx       <= '0;
        tcnt      <= '0;
      end else begin
        if (!busy) begin
          if (!buf_empty) begin
            sh        <= dbuf;
            par_on    <= par_en;
            par_q     <= (^dbuf) ^ par_odd;
            buf_empty <= 1'b1;
            tx_end    <= 1'b0;
            busy      <= 1'b1;
            idx       <= '0;
            tcnt      <= '0;
          end
        end else if (tick16) begin
          if (tcnt == CW'(OSR - 1)) begin
            tcnt <= '0;
            if (idx == last_idx) begin
              busy <= 1'b0;
              if (buf_empty) tx_end <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              if (idx != '0 && idx <= BW'(DW)) sh <= sh >> 1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        if (wr_stb) begin
          dbuf      <= wr_data;
          buf_empty <= 1'b0;
        end
      end
    end
  end
endmodule

module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic port_wr,
  input logic port_din,
  input logic txd,
  input logic buf_empty,
  input logic tx_end
);
  assert_port_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_wr) && !tx_en) |-> (txd == $past(port_din)));

  assert_idle_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && buf_empty && tx_end) |-> txd);

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> !buf_empty);

  assert_end_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_end) && $past(tx_en)) |-> $past(txd));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (buf_empty && tx_end));
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (.*);

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  logic clk = 0, rst_n = 0, tick16 = 0, wr_stb = 0, tx_en = 0;
  logic port_wr = 0, port_din = 0, par_en = 0, par_odd = 0;
  logic [7:0] wr_data = '0;
  logic txd, buf_empty, tx_end;
  int nchk = 0, nfail = 0;

  localparam int BIT = 64;
  localparam int NV  = 6;
  localparam logic [9:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0}, {8'h3C, 1'b1, 1'b1},
    {8'h01, 1'b1, 1'b0}, {8'hFE, 1'b0, 1'b0}, {8'h80, 1'b1, 1'b1}};

  uart_tx_brk u_uart_tx_brk (.*);

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1;
      @(negedge clk);
      tick16 = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk); wr_data = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic wait_start();
    int t = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    chk("R3 start seen", 32'(t < 5000), 1);
  endtask

  task automatic recv(logic [7:0] d, logic pe, logic po, string req);
    wait_start();
    repeat (BIT/2) @(negedge clk);
    chk({req, " start"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      chk({req, " data"}, txd, d[i]);
    end
    if (pe) begin
      repeat (BIT) @(negedge clk);
      chk({req, " parity"}, txd, (^d) ^ po);
    end
    repeat (BIT) @(negedge clk);
    chk({req, " stop"}, txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 tx_end", tx_end, 1);

    tx_en = 1;
    for (int v = 0; v < NV; v++) begin
      par_en = VEC[v][1]; par_odd = VEC[v][0];
      put(VEC[v][9:2]);
      repeat (2) @(negedge clk);
      chk("R5 buf_empty after load", buf_empty, 1);
      chk("R6 tx_end low in frame", tx_end, 0);
      recv(VEC[v][9:2], VEC[v][1], VEC[v][0], "R3");
      repeat (BIT/2 + 8) @(negedge clk);
      chk("R6 tx_end after stop", tx_end, 1);
    end

    begin : start_len_R4
      int n = 0;
      par_en = 0;
      put(8'h01);
      wait_start();
      while (txd === 1'b0 && n < 200) begin @(negedge clk); n++; end
      chk("R4 start bit length in range", 32'(n >= 60 && n <= 68), 1);
      repeat (12 * BIT) @(negedge clk);
    end

    put(8'h5A);
    repeat (2) @(negedge clk);
    put(8'hC3);
    recv(8'h5A, 0, 0, "R10 first");
    recv(8'hC3, 0, 0, "R10 second");
    repeat (BIT) @(negedge clk);

    put(8'h00);
    wait_start();
    repeat (40) @(negedge clk);
    tx_en = 0;
    #1 chk("R7 line follows port at abort", txd, 1);
    @(negedge clk);
    chk("R7 buf_empty", buf_empty, 1);
    chk("R7 tx_end", tx_end, 1);
    tx_en = 1;
    begin : no_resume_R7
      int lows = 0;
      for (int i = 0; i < 12 * BIT; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk("R7 no resume", lows, 0);
    end

    tx_en = 0;
    put(8'h00);
    tx_en = 1;
    begin : ignore_R8
      int lows = 0;
      for (int i = 0; i < 4 * BIT; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk("R8 nothing sent", lows, 0);
      chk("R8 buf_empty", buf_empty, 1);
    end

    port_wr = 1; port_din = 0;
    @(negedge clk); port_wr = 0;
    repeat (4) @(negedge clk);
    chk("R3 port ignored while enabled", txd, 1);
    tx_en = 0;
    begin : brk_R9
      int highs = 0;
      for (int i = 0; i < 500; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
      chk("R9 break held low", highs, 0);
    end
    port_wr = 1; port_din = 1;
    @(negedge clk); port_wr = 0;
    @(negedge clk);
    chk("R2 port back to mark", txd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule